// File: doc/BRIEF.md
# Power Mode Supervisor

This block is the mode controller of a supply and bus-transceiver companion chip. It sequences the chip through six operating states: a reset phase, a startup phase that waits for the first watchdog service, full-power operation, a low-power state that keeps the regulator on at reduced current, a low-power state that turns the regulator off, and a power-down state reached after a long supply failure. It drives the reset pin level, the regulator enable, a reduced-current request, an active-low interrupt pulse and a mode code that neighbouring logic uses to gate peripherals.

All durations come from one tick prescaler. A tick lasts `TICK_DIV` clock cycles, and each timed phase is a count of ticks set by a parameter. Simulation can therefore use short counts while silicon uses the real milliseconds. Mode requests reach the block already decoded from the serial interface. Wake sources are two switch inputs, a bus wake strobe and the chip-select line.

Top module: `pwr_supervisor`

## Requirements
- R1: After power-on reset, and after any entry to Reset, the block stays in Reset (`mode_state` 0, `reset_n_out` low) for RST_TICKS*TICK_DIV cycles while `supply_ok` is high. It then moves to Normal Request (1) if `wd_sel` is high, or to Normal (2) if it is low. A change of `supply_ok` while in Reset restarts the count.
- R2: In Normal Request, a command with `cmd_mode`=2'b10 moves to Normal on the next edge. With `wd_sel` high and no such command for NRQ_TICKS*TICK_DIV cycles, the block returns to Reset. With `wd_sel` low there is no timeout.
- R3: In Normal, `wd_fail` with `wd_sel` high returns to Reset on the next edge. `wd_fail` with `wd_sel` low has no effect, and `cmd_mode`=2'b11 keeps the block in Normal.
- R4: In Normal, a command with `cmd_mode`=2'b00 enters Sleep (4) and one with 2'b01 enters Stop (3), on the next edge.
- R5: `reset_n_out` is high only in Normal Request, Normal and Stop. `reg_en` is low only in Sleep. `reg_lowpwr` is high only in Stop. `periph_act` is high in Normal Request and Normal. `supply_ok` is ignored in Sleep.
- R6: A wake event is any of these: a change of `sw1` or `sw2` between consecutive cycles, `bus_wake` high, or a low-to-high edge on `cs_n`. A falling `cs_n` does not wake the block.
- R7: A wake in Sleep moves to Reset. A wake in Stop moves to Normal Request and starts an interrupt pulse.
- R8: `int_n` goes low on the edge that enters Normal Request from Stop. It stays low for exactly INT_TICKS*TICK_DIV cycles.
- R9: In Reset, `supply_ok` low for PDN_TICKS*TICK_DIV cycles with `uv_flag` low enters Power Down (5). `uv_flag` high holds the count at zero. Power Down returns to Reset once `supply_ok` is high.
- R10: `supply_ok` low in Normal Request, Normal or Stop moves to Reset on the next edge, ahead of any command, watchdog or wake condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Regulated output within limits |
| wd_sel | input | 1 | Watchdog fitted |
| wd_fail | input | 1 | Watchdog window violation strobe |
| uv_flag | input | 1 | Battery undervoltage flag |
| cmd_valid | input | 1 | Decoded mode command strobe |
| cmd_mode | input | 2 | 00 sleep, 01 stop, 10 normal with watchdog clear, 11 normal |
| sw1 | input | 1 | Switch sense input 1 |
| sw2 | input | 1 | Switch sense input 2 |
| bus_wake | input | 1 | Bus wake detected |
| cs_n | input | 1 | Serial chip select |
| reset_n_out | output | 1 | Reset pin level |
| reg_en | output | 1 | Regulator enable |
| reg_lowpwr | output | 1 | Regulator reduced-current request |
| int_n | output | 1 | Interrupt pulse, active low |
| periph_act | output | 1 | Full-power peripherals enabled |
| mode_state | output | 3 | Current state code |

## Verification
Power Down is the hardest state to reach from the ports. The bench must first force Reset by dropping the supply in Normal, then hold the supply low with the undervoltage flag set for longer than the power-down window to show the count is held. Only then does it clear the flag and wait out the full window. Interrupt width is measured by sampling `int_n` every cycle after a switch-change wake from Stop. The exact reset and startup-timeout boundaries are probed one cycle before and on the expected edge.

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int TICK_DIV  = 16,
  parameter int RST_TICKS = 1000,
  parameter int NRQ_TICKS = 150000,
  parameter int PDN_TICKS = 150000,
  parameter int INT_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       wd_sel,
  input  logic       wd_fail,
  input  logic       uv_flag,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_mode,
  input  logic       sw1,
  input  logic       sw2,
  input  logic       bus_wake,
  input  logic       cs_n,
  output logic       reset_n_out,
  output logic       reg_en,
  output logic       reg_lowpwr,
  output logic       int_n,
  output logic       periph_act,
  output logic [2:0] mode_state
);

  localparam logic [2:0] S_RST = 3'd0, S_NRQ = 3'd1, S_NRM = 3'd2,
                         S_STP = 3'd3, S_SLP = 3'd4, S_PDN = 3'd5;
  localparam int TMAX1   = (RST_TICKS > NRQ_TICKS) ? RST_TICKS : NRQ_TICKS;
  localparam int TMAX    = (TMAX1 > PDN_TICKS) ? TMAX1 : PDN_TICKS;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int PW      = $clog2(TICK_DIV + 1);
  localparam int INT_LEN = INT_TICKS * TICK_DIV;
  localparam int IW      = $clog2(INT_LEN + 1);

  logic [2:0]    st, nx;
  logic [PW-1:0] pre;
  logic [TW-1:0] tmr, lim;
  logic [IW-1:0] icnt;
  logic          sw1_q, sw2_q, cs_q, sup_q;

  wire tick    = (pre == PW'(TICK_DIV - 1));
  wire in_rst  = (st == S_RST);
  wire hold    = in_rst && !supply_ok && uv_flag;
  wire sup_chg = in_rst && (supply_ok != sup_q);
  wire expire  = tick && !hold && !sup_chg && (tmr == lim - 1'b1);
  wire wake    = (sw1 ^ sw1_q) | (sw2 ^ sw2_q) | bus_wake | (cs_n & ~cs_q);
  wire clr_cmd = cmd_valid && (cmd_mode == 2'b10);
  wire restart = (nx != st) || sup_chg || hold;

  always_comb begin
    case (st)
      S_RST:   lim = supply_ok ? TW'(RST_TICKS) : TW'(PDN_TICKS);
      S_NRQ:   lim = TW'(NRQ_TICKS);
      default: lim = '0;
    endcase
  end

  always_comb begin
    nx = st;
    case (st)
      S_RST: if (expire) nx = supply_ok ? (wd_sel ? S_NRQ : S_NRM) : S_PDN;
      S_NRQ: begin
        if (!supply_ok)             nx = S_RST;
        else if (clr_cmd)           nx = S_NRM;
        else if (wd_sel && expire)  nx = S_RST;
      end
      S_NRM: begin
        if (!supply_ok)                             nx = S_RST;
        else if (wd_sel && wd_fail)                 nx = S_RST;
        else if (cmd_valid && cmd_mode == 2'b00)    nx = S_SLP;
        else if (cmd_valid && cmd_mode == 2'b01)    nx = S_STP;
      end
      S_STP: begin
        if (!supply_ok) nx = S_RST;
        else if (wake)  nx = S_NRQ;
      end
      S_SLP: if (wake) nx = S_RST;
      S_PDN: if (supply_ok) nx = S_RST;
      default: nx = S_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_RST;
      pre   <= '0;
      tmr   <= '0;
      icnt  <= '0;
      sw1_q <= 1'b0;
      sw2_q <= 1'b0;
      cs_q  <= 1'b1;
      sup_q <= 1'b1;
    end else begin
      st    <= nx;
      sw1_q <= sw1;
      sw2_q <= sw2;
      cs_q  <= cs_n;
      sup_q <= supply_ok;
      if (restart) begin
        pre <= '0;
        tmr <= '0;
      end else if (tick) begin
        pre <= '0;
        if (st == S_RST || st == S_NRQ) tmr <= tmr + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      if (st == S_STP && nx == S_NRQ) icnt <= IW'(INT_LEN);
      else if (icnt != '0)            icnt <= icnt - 1'b1;
    end
  end

  assign reset_n_out = (st == S_NRQ) || (st == S_NRM) || (st == S_STP);
  assign reg_en      = (st != S_SLP);
  assign reg_lowpwr  = (st == S_STP);
  assign periph_act  = (st == S_NRQ) || (st == S_NRM);
  assign int_n       = (icnt == '0);
  assign mode_state  = st;

endmodule

module pwr_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       wd_sel,
  input logic       wd_fail,
  input logic       bus_wake,
  input logic [2:0] mode_state,
  input logic       reset_n_out,
  input logic       int_n
);
  AST_SUPPLY_LOW_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && (mode_state == 3'd1 || mode_state == 3'd2 || mode_state == 3'd3))
      |=> mode_state == 3'd0); // R10
  AST_WD_FAIL_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == 3'd2 && supply_ok && wd_sel && wd_fail) |=> mode_state == 3'd0); // R3
  AST_STOP_BUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == 3'd3 && supply_ok && bus_wake) |=> (mode_state == 3'd1 && !int_n)); // R7
  AST_SLEEP_BUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == 3'd4 && bus_wake) |=> mode_state == 3'd0); // R7
  AST_RESET_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_state == 3'd0) |=> (mode_state == 3'd0 || mode_state == 3'd1 ||
                              mode_state == 3'd2 || mode_state == 3'd5)); // R1
  AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n_out) |-> (mode_state == 3'd1 || mode_state == 3'd2)); // R5
  AST_INT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> (mode_state == 3'd1 && $past(mode_state) == 3'd3)); // R8
endmodule

bind pwr_supervisor pwr_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_sel(wd_sel),
  .wd_fail(wd_fail), .bus_wake(bus_wake), .mode_state(mode_state),
  .reset_n_out(reset_n_out), .int_n(int_n)
);

// File: tb/tb_pwr_supervisor.sv
module tb_pwr_supervisor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, supply_ok, wd_sel, wd_fail, uv_flag, cmd_valid;
  logic [1:0] cmd_mode;
  logic sw1, sw2, bus_wake, cs_n;
  logic reset_n_out, reg_en, reg_lowpwr, int_n, periph_act;
  logic [2:0] mode_state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_supervisor #(.TICK_DIV(4), .RST_TICKS(5), .NRQ_TICKS(8), .PDN_TICKS(6), .INT_TICKS(3)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_sel(wd_sel), .wd_fail(wd_fail),
    .uv_flag(uv_flag), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode), .sw1(sw1), .sw2(sw2),
    .bus_wake(bus_wake), .cs_n(cs_n), .reset_n_out(reset_n_out), .reg_en(reg_en),
    .reg_lowpwr(reg_lowpwr), .int_n(int_n), .periph_act(periph_act), .mode_state(mode_state));

  typedef struct packed {
    logic sup, wds, wdf, cv; logic [1:0] cm;
    logic uv, s1, s2, bw, cs;
    logic [7:0] n;
    logic [2:0] st; logic rn, re, lp, in;
    logic [3:0] req;
  } vec_t;

  // fields: sup wds wdf cv cm uv s1 s2 bw cs | cycles | state rstn regen lowpwr int | req
  localparam vec_t TBL [0:28] = '{
    {4'b1100,2'b11,5'b00001, 8'd10, 3'd0,4'b0101, 4'd1},  // R1 still in reset
    {4'b1100,2'b11,5'b00001, 8'd15, 3'd1,4'b1101, 4'd1},  // R1 to startup
    {4'b1101,2'b10,5'b00001, 8'd2,  3'd2,4'b1101, 4'd2},  // R2 clear
    {4'b1101,2'b11,5'b00001, 8'd2,  3'd2,4'b1101, 4'd3},  // R3 plain normal
    {4'b1101,2'b01,5'b00001, 8'd2,  3'd3,4'b1111, 4'd4},  // R4 stop, R5 outputs
    {4'b1100,2'b11,5'b01001, 8'd2,  3'd1,4'b1100, 4'd7},  // R7 sw1 wake from stop
    {4'b1101,2'b10,5'b01001, 8'd2,  3'd2,4'b1100, 4'd2},  // R2 clear, pulse running
    {4'b1100,2'b11,5'b01001, 8'd12, 3'd2,4'b1101, 4'd8},  // R8 pulse over
    {4'b1101,2'b00,5'b01001, 8'd2,  3'd4,4'b0001, 4'd4},  // R4 sleep
    {4'b0100,2'b11,5'b01001, 8'd5,  3'd4,4'b0001, 4'd5},  // R5 supply ignored in sleep
    {4'b0100,2'b11,5'b01011, 8'd2,  3'd0,4'b0101, 4'd7},  // R7 bus wake from sleep
    {4'b1100,2'b11,5'b01001, 8'd30, 3'd1,4'b1101, 4'd1},  // R1
    {4'b1100,2'b11,5'b01001, 8'd40, 3'd0,4'b0101, 4'd2},  // R2 startup timeout
    {4'b1100,2'b11,5'b01001, 8'd10, 3'd1,4'b1101, 4'd1},  // R1
    {4'b1001,2'b10,5'b01001, 8'd2,  3'd2,4'b1101, 4'd2},  // R2
    {4'b1010,2'b11,5'b01001, 8'd3,  3'd2,4'b1101, 4'd3},  // R3 fail ignored
    {4'b1110,2'b11,5'b01001, 8'd2,  3'd0,4'b0101, 4'd3},  // R3 fail honoured
    {4'b1000,2'b11,5'b01001, 8'd25, 3'd2,4'b1101, 4'd1},  // R1 straight to normal
    {4'b0000,2'b11,5'b01001, 8'd1,  3'd0,4'b0101, 4'd10}, // R10
    {4'b0000,2'b11,5'b11001, 8'd40, 3'd0,4'b0101, 4'd9},  // R9 uv holds
    {4'b0000,2'b11,5'b01001, 8'd30, 3'd5,4'b0101, 4'd9},  // R9 power down
    {4'b1000,2'b11,5'b01001, 8'd2,  3'd0,4'b0101, 4'd9},  // R9 leave power down
    {4'b1000,2'b11,5'b01001, 8'd25, 3'd2,4'b1101, 4'd1},  // R1
    {4'b1001,2'b01,5'b01001, 8'd2,  3'd3,4'b1111, 4'd4},  // R4
    {4'b1000,2'b11,5'b01000, 8'd3,  3'd3,4'b1111, 4'd6},  // R6 falling cs
    {4'b1000,2'b11,5'b01001, 8'd2,  3'd1,4'b1100, 4'd6},  // R6 rising cs
    {4'b1001,2'b10,5'b01001, 8'd2,  3'd2,4'b1100, 4'd2},  // R2
    {4'b1001,2'b01,5'b01001, 8'd14, 3'd3,4'b1111, 4'd8},  // R8 pulse ended
    {4'b0000,2'b11,5'b01001, 8'd1,  3'd0,4'b0101, 4'd10}  // R10 from stop
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; supply_ok = 1; wd_sel = 1; wd_fail = 0; uv_flag = 0;
    cmd_valid = 0; cmd_mode = 2'b11; sw1 = 0; sw2 = 0; bus_wake = 0; cs_n = 1;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic apply(input vec_t v);
    {supply_ok, wd_sel, wd_fail, cmd_valid} = {v.sup, v.wds, v.wdf, v.cv};
    cmd_mode = v.cm; uv_flag = v.uv; sw1 = v.s1; sw2 = v.s2; bus_wake = v.bw; cs_n = v.cs;
    @(negedge clk);
    wd_fail = 0; cmd_valid = 0; bus_wake = 0;
    repeat (int'(v.n) - 1) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset state", {mode_state, reset_n_out}, {3'd0, 1'b0});
    chk("R5 reset outputs", {reg_en, reg_lowpwr, int_n}, 3'b101);

    for (int i = 0; i < 29; i++) begin
      apply(TBL[i]);
      if ({mode_state, reset_n_out, reg_en, reg_lowpwr, int_n} !==
          {TBL[i].st, TBL[i].rn, TBL[i].re, TBL[i].lp, TBL[i].in}) begin
        errors++;
        $display("FAIL R%0d vector %0d actual %0h expected %0h", TBL[i].req, i,
                 {mode_state, reset_n_out, reg_en, reg_lowpwr, int_n},
                 {TBL[i].st, TBL[i].rn, TBL[i].re, TBL[i].lp, TBL[i].in});
      end
      checks++;
    end

    // R1 exact reset dwell: 20 cycles
    do_reset();
    repeat (19) @(negedge clk);
    chk("R1 one cycle before exit", mode_state, 3'd0);
    @(negedge clk);
    chk("R1 exit edge", mode_state, 3'd1);
    chk("R5 periph_act in startup", periph_act, 1'b1);
    // R2 exact startup timeout: 32 cycles
    repeat (31) @(negedge clk);
    chk("R2 one cycle before timeout", mode_state, 3'd1);
    @(negedge clk);
    chk("R2 timeout edge", mode_state, 3'd0);
    repeat (20) @(negedge clk);
    chk("R1 second startup", mode_state, 3'd1);
    cmd_valid = 1; cmd_mode = 2'b10; @(negedge clk);
    cmd_mode = 2'b01; @(negedge clk);
    cmd_valid = 0;
    chk("R4 stop entered", mode_state, 3'd3);
    // R6 sw2 change wakes, R8 pulse width
    sw2 = 1; @(negedge clk);
    chk("R7 wake to startup", mode_state, 3'd1);
    begin
      int lows = 0;
      for (int k = 0; k < 20; k++) begin
        if (!int_n) lows++;
        @(negedge clk);
      end
      chk("R8 interrupt width", lows, 12);
    end
    // R10 supply low wins over clear command
    supply_ok = 0; cmd_valid = 1; cmd_mode = 2'b10; @(negedge clk);
    cmd_valid = 0;
    chk("R10 priority over clear", mode_state, 3'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule